// File: doc/BRIEF.md
# PFC and PWM Protection Sequencer

This block supervises a two-stage power supply made of a boost power-factor stage followed by a pulse-width-modulated converter. It does no analog sensing itself. External comparators turn the supply rail, the averaged line voltage, the boost feedback node, the voltage-amplifier output and the soft-start capacitor into single-bit flags. From those flags the block decides whether the boost stage may switch and whether the downstream converter may run. It also controls when the soft-start capacitor is discharged.

Two timers are clocked by a one-microsecond tick. One debounces line brownout. The other measures how long the line has been sagging. Once brownout or sag protection trips, the result is latched, and only a line level above the restart threshold releases it. The block also applies supply lockout, supply over-voltage, boost over-voltage, open-loop and low-amplifier shutdowns, and it gates the converter on the state of the boost output. Every output is registered, and each shutdown reason is reported as a priority-encoded status code.

Top module: `psu_guard_seq`

## Requirements
- R1: Both stages stay off from reset until `sup_start_ok` is seen high. After that, supply lockout holds both stages off from the edge after `sup_hold_ok` goes low until `sup_start_ok` is seen high again.
- R2: `sup_over` high latches a supply over-voltage that holds both stages off. The latch clears only when `sup_over_hold` is low.
- R3: A brownout is latched, and the boost stage is turned off, on the tick that makes `BROWN_TICKS` consecutive counted ticks with `rms_brown_ok` low. A shorter dip has no effect. The converter keeps running through a brownout.
- R4: The brownout latch is set out of reset. The brownout and sag latches clear only on an edge where `rms_restart` is high. A line level between the trip and restart thresholds leaves both stages off.
- R5: When `rms_sag_ok` stays low for `SAG_TICKS` consecutive counted ticks, the sag latch is set and both stages are held off.
- R6: `rms_sag_ok` low together with `fb_hold` low sets the sag latch at once, on that edge.
- R7: The converter may start only after `fb_ready` has been seen high. Once `fb_hold` goes low, the converter stops, and it waits for `fb_ready` again.
- R8: `fb_over` high latches boost over-voltage and stops the boost stage only. The latch clears when `fb_over_hold` is low.
- R9: `fb_loop_ok` low or `vamp_ok` low turns the boost stage off for exactly the cycles in which it holds. Nothing is latched.
- R10: A converter fault (supply lockout or over-voltage, sag latch, or feedback not ready) asserts `ss_discharge` and clears `pwm_en`. After the fault is gone, one charging cycle with both signals low follows. `pwm_en` rises only on the edge after `ss_ready` is seen high in that charging phase. A fault on that same edge wins.
- R11: `status` reports the first true item in this priority order: 1 lockout, 2 supply over-voltage, 3 sag, 4 brownout, 5 boost over-voltage, 6 open loop or low amplifier, 7 converter not running. Otherwise it reports 0.
- R12: All outputs are registered and respond on the first clock edge after a flag changes. Reset gives `pfc_en`=0, `pwm_en`=0, `ss_discharge`=1 and `status`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_us | input | 1 | One-cycle strobe each microsecond |
| sup_start_ok | input | 1 | Supply above turn-on level |
| sup_hold_ok | input | 1 | Supply above turn-off level |
| sup_over | input | 1 | Supply above over-voltage level |
| sup_over_hold | input | 1 | Supply above over-voltage release level |
| rms_restart | input | 1 | Line RMS above restart level |
| rms_brown_ok | input | 1 | Line RMS above brownout level |
| rms_sag_ok | input | 1 | Line RMS above sag level |
| fb_ready | input | 1 | Boost feedback above converter-ready level |
| fb_hold | input | 1 | Boost feedback above converter-drop level |
| fb_over | input | 1 | Boost feedback above over-voltage level |
| fb_over_hold | input | 1 | Boost feedback above over-voltage release level |
| fb_loop_ok | input | 1 | Boost feedback above open-loop level |
| vamp_ok | input | 1 | Voltage amplifier output above minimum |
| ss_ready | input | 1 | Soft-start level above converter-start level |
| pfc_en | output | 1 | Boost stage enable |
| pwm_en | output | 1 | Converter enable |
| ss_discharge | output | 1 | Discharge soft-start capacitor |
| status | output | 3 | Highest-priority shutdown reason |

## Verification
The most delicate collision happens in the charging phase. `ss_ready` can rise on the same edge that a converter fault arrives. The bench provokes this by raising `ss_ready` and dropping `fb_hold` and `fb_ready` in one cycle. It requires `ss_discharge` to stay high and `pwm_en` to stay low. A second overlap uses a supply lockout together with an immediate sag trip, and the status code must report the lockout. A behavioural reference model checks every output on every cycle, so these events are judged cycle by cycle.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;

   typedef enum logic [2:0] {
      ST_NORMAL   = 3'd0,
      ST_SUP_LOW  = 3'd1,
      ST_SUP_HIGH = 3'd2,
      ST_SAG      = 3'd3,
      ST_BROWN    = 3'd4,
      ST_FB_HIGH  = 3'd5,
      ST_LOOP_BAD = 3'd6,
      ST_PWM_WAIT = 3'd7
   } seq_status_e;

   typedef enum logic [1:0] {
      PW_OFF    = 2'd0,
      PW_CHARGE = 2'd1,
      PW_RUN    = 2'd2
   } pwm_phase_e;

endpackage

// File: rtl/psu_hyst_latch.sv
module psu_hyst_latch #(
   parameter bit RST_VAL  = 1'b0,
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic nxt_o
);

   logic q;
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_first
         assign nxt = set_i | (q & ~clr_i);
      end else begin : g_clr_first
         assign nxt = ~clr_i & (set_i | q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end

   assign nxt_o = nxt;

endmodule

// File: rtl/psu_dwell_timer.sv
module psu_dwell_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic cond_i,
   output logic expire_o
);

   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("psu_dwell_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          at_last;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (!cond_i)            cnt_q <= '0;
      else if (tick_i && !at_last) cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = cond_i & tick_i & at_last;

   // R3 / R5: the dwell count never passes its limit and restarts whenever the condition drops
   a_r3_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= LAST);
   a_r5_cnt_restart : assert property (@(posedge clk) disable iff (!rst_n)
      !cond_i |=> cnt_q == '0);

endmodule

// File: rtl/psu_guard_seq.sv
module psu_guard_seq
   import psu_seq_pkg::*;
#(
   parameter int unsigned BROWN_TICKS = 1_000_000,
   parameter int unsigned SAG_TICKS   = 33_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_us,
   input  logic       sup_start_ok,
   input  logic       sup_hold_ok,
   input  logic       sup_over,
   input  logic       sup_over_hold,
   input  logic       rms_restart,
   input  logic       rms_brown_ok,
   input  logic       rms_sag_ok,
   input  logic       fb_ready,
   input  logic       fb_hold,
   input  logic       fb_over,
   input  logic       fb_over_hold,
   input  logic       fb_loop_ok,
   input  logic       vamp_ok,
   input  logic       ss_ready,
   output logic       pfc_en,
   output logic       pwm_en,
   output logic       ss_discharge,
   output logic [2:0] status
);

   generate
      if (SAG_TICKS >= BROWN_TICKS) begin : g_bad_order
         $error("psu_guard_seq: sag window must be shorter than brownout debounce");
      end
   endgenerate

   // ---- dwell timers ----
   logic brown_exp, sag_exp;

   psu_dwell_timer #(.LIMIT(BROWN_TICKS)) u_brown_tmr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_us),
      .cond_i(~rms_brown_ok), .expire_o(brown_exp));

   psu_dwell_timer #(.LIMIT(SAG_TICKS)) u_sag_tmr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_us),
      .cond_i(~rms_sag_ok), .expire_o(sag_exp));

   // ---- hysteresis and fault latches (next-state values) ----
   logic uvlo_ok, sup_ov, brown_lat, sag_lat, fb_ov, pwm_rdy;

   psu_hyst_latch #(.RST_VAL(1'b0)) u_uvlo (
      .clk(clk), .rst_n(rst_n), .set_i(sup_start_ok), .clr_i(~sup_hold_ok), .nxt_o(uvlo_ok));

   psu_hyst_latch #(.RST_VAL(1'b0)) u_sup_ov (
      .clk(clk), .rst_n(rst_n), .set_i(sup_over), .clr_i(~sup_over_hold), .nxt_o(sup_ov));

   psu_hyst_latch #(.RST_VAL(1'b1)) u_brown (
      .clk(clk), .rst_n(rst_n), .set_i(brown_exp), .clr_i(rms_restart), .nxt_o(brown_lat));

   psu_hyst_latch #(.RST_VAL(1'b0)) u_sag (
      .clk(clk), .rst_n(rst_n), .set_i(sag_exp | (~rms_sag_ok & ~fb_hold)),
      .clr_i(rms_restart), .nxt_o(sag_lat));

   psu_hyst_latch #(.RST_VAL(1'b0)) u_fb_ov (
      .clk(clk), .rst_n(rst_n), .set_i(fb_over), .clr_i(~fb_over_hold), .nxt_o(fb_ov));

   psu_hyst_latch #(.RST_VAL(1'b0)) u_pwm_rdy (
      .clk(clk), .rst_n(rst_n), .set_i(fb_ready), .clr_i(~fb_hold), .nxt_o(pwm_rdy));

   // ---- enable decisions ----
   logic supply_ok, loop_ok, pfc_go, pwm_fault;

   assign supply_ok = uvlo_ok & ~sup_ov;
   assign loop_ok   = fb_loop_ok & vamp_ok;
   assign pfc_go    = supply_ok & ~brown_lat & ~sag_lat & ~fb_ov & loop_ok;
   assign pwm_fault = ~supply_ok | sag_lat | ~pwm_rdy;

   // ---- converter soft-start sequencing ----
   pwm_phase_e phase_q, phase_nxt;

   always_comb begin
      phase_nxt = phase_q;
      if (pwm_fault) begin
         phase_nxt = PW_OFF;
      end else begin
         unique case (phase_q)
            PW_OFF:    phase_nxt = PW_CHARGE;
            PW_CHARGE: phase_nxt = ss_ready ? PW_RUN : PW_CHARGE;
            default:   phase_nxt = PW_RUN;
         endcase
      end
   end

   // ---- status priority encoder ----
   seq_status_e stat_nxt;

   always_comb begin
      if (!uvlo_ok)              stat_nxt = ST_SUP_LOW;
      else if (sup_ov)           stat_nxt = ST_SUP_HIGH;
      else if (sag_lat)          stat_nxt = ST_SAG;
      else if (brown_lat)        stat_nxt = ST_BROWN;
      else if (fb_ov)            stat_nxt = ST_FB_HIGH;
      else if (!loop_ok)         stat_nxt = ST_LOOP_BAD;
      else if (phase_nxt != PW_RUN) stat_nxt = ST_PWM_WAIT;
      else                       stat_nxt = ST_NORMAL;
   end

   // ---- output registers ----
   logic        pfc_q;
   seq_status_e stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pfc_q   <= 1'b0;
         phase_q <= PW_OFF;
         stat_q  <= ST_SUP_LOW;
      end else begin
         pfc_q   <= pfc_go;
         phase_q <= phase_nxt;
         stat_q  <= stat_nxt;
      end
   end

   assign pfc_en       = pfc_q;
   assign pwm_en       = (phase_q == PW_RUN);
   assign ss_discharge = (phase_q == PW_OFF);
   assign status       = stat_q;

   // ---- assertions ----
   // R1: supply lockout forces both stages off on the next edge
   a_r1_lockout : assert property (@(posedge clk) disable iff (!rst_n)
      !sup_hold_ok |=> (!pfc_en && !pwm_en));
   // R2: supply over-voltage forces both stages off
   a_r2_sup_over : assert property (@(posedge clk) disable iff (!rst_n)
      sup_over |=> (!pfc_en && !pwm_en));
   // R6: immediate sag trip
   a_r6_sag_now : assert property (@(posedge clk) disable iff (!rst_n)
      (!rms_sag_ok && !fb_hold) |=> (!pfc_en && !pwm_en));
   // R8: boost over-voltage stops the boost stage
   a_r8_fb_over : assert property (@(posedge clk) disable iff (!rst_n)
      fb_over |=> !pfc_en);
   // R9: open loop or low amplifier stops the boost stage
   a_r9_loop : assert property (@(posedge clk) disable iff (!rst_n)
      (!fb_loop_ok || !vamp_ok) |=> !pfc_en);
   // R10: converter starts only after soft-start was seen ready
   a_r10_ss_gate : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_en) |-> $past(ss_ready));
   // R10: leaving discharge always passes through a charging cycle
   a_r10_charge : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ss_discharge) |-> !pwm_en);
   // R4: brownout cannot release while the line is below restart level
   a_r4_no_release : assert property (@(posedge clk) disable iff (!rst_n)
      (!rms_restart && !pfc_en && status == 3'd4) |=> !pfc_en);

endmodule

// File: tb/sim_psu_guard_seq.sv
module sim_psu_guard_seq;

   localparam int BT = 20;
   localparam int ST = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic tick_us = 1'b0;
   logic sup_start_ok = 0, sup_hold_ok = 0, sup_over = 0, sup_over_hold = 0;
   logic rms_restart = 0, rms_brown_ok = 0, rms_sag_ok = 0;
   logic fb_ready = 0, fb_hold = 0, fb_over = 0, fb_over_hold = 0, fb_loop_ok = 0;
   logic vamp_ok = 0, ss_ready = 0;
   logic pfc_en, pwm_en, ss_discharge;
   logic [2:0] status;

   psu_guard_seq #(.BROWN_TICKS(BT), .SAG_TICKS(ST)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
      .sup_start_ok(sup_start_ok), .sup_hold_ok(sup_hold_ok),
      .sup_over(sup_over), .sup_over_hold(sup_over_hold),
      .rms_restart(rms_restart), .rms_brown_ok(rms_brown_ok), .rms_sag_ok(rms_sag_ok),
      .fb_ready(fb_ready), .fb_hold(fb_hold), .fb_over(fb_over),
      .fb_over_hold(fb_over_hold), .fb_loop_ok(fb_loop_ok),
      .vamp_ok(vamp_ok), .ss_ready(ss_ready),
      .pfc_en(pfc_en), .pwm_en(pwm_en), .ss_discharge(ss_discharge), .status(status));

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   string req = "R12";

   // ---- behavioural reference model ----
   int m_uvlo = 0, m_sov = 0, m_brown = 1, m_sag = 0, m_fov = 0, m_rdy = 0;
   int m_phase = 0, bcnt = 0, scnt = 0;
   int m_pfc = 0, m_pwm = 0, m_dis = 1, m_stat = 1;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_uvlo = 0; m_sov = 0; m_brown = 1; m_sag = 0; m_fov = 0; m_rdy = 0;
         m_phase = 0; bcnt = 0; scnt = 0;
         m_pfc = 0; m_pwm = 0; m_dis = 1; m_stat = 1;
      end else begin
         int bexp, sexp, supok, lok, flt;
         bexp = (!rms_brown_ok && tick_us && bcnt == BT-1) ? 1 : 0;
         sexp = (!rms_sag_ok && tick_us && scnt == ST-1) ? 1 : 0;
         if (rms_brown_ok) bcnt = 0; else if (tick_us && bcnt < BT-1) bcnt++;
         if (rms_sag_ok)   scnt = 0; else if (tick_us && scnt < ST-1) scnt++;
         if (sup_start_ok) m_uvlo = 1; else if (!sup_hold_ok) m_uvlo = 0;
         if (sup_over) m_sov = 1; else if (!sup_over_hold) m_sov = 0;
         if (bexp) m_brown = 1; else if (rms_restart) m_brown = 0;
         if (sexp || (!rms_sag_ok && !fb_hold)) m_sag = 1; else if (rms_restart) m_sag = 0;
         if (fb_over) m_fov = 1; else if (!fb_over_hold) m_fov = 0;
         if (fb_ready) m_rdy = 1; else if (!fb_hold) m_rdy = 0;
         supok = (m_uvlo && !m_sov) ? 1 : 0;
         lok = (fb_loop_ok && vamp_ok) ? 1 : 0;
         m_pfc = (supok && !m_brown && !m_sag && !m_fov && lok) ? 1 : 0;
         flt = (!supok || m_sag || !m_rdy) ? 1 : 0;
         if (flt) m_phase = 0;
         else if (m_phase == 0) m_phase = 1;
         else if (m_phase == 1 && ss_ready) m_phase = 2;
         m_pwm = (m_phase == 2) ? 1 : 0;
         m_dis = (m_phase == 0) ? 1 : 0;
         if (!m_uvlo) m_stat = 1;
         else if (m_sov) m_stat = 2;
         else if (m_sag) m_stat = 3;
         else if (m_brown) m_stat = 4;
         else if (m_fov) m_stat = 5;
         else if (!lok) m_stat = 6;
         else if (m_phase != 2) m_stat = 7;
         else m_stat = 0;
      end
   end

   task automatic chk(string r, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(req, "model pfc_en", int'(pfc_en), m_pfc);
         chk(req, "model pwm_en", int'(pwm_en), m_pwm);
         chk(req, "model ss_discharge", int'(ss_discharge), m_dis);
         chk(req, "model status", int'(status), m_stat);
         tick_us = ~tick_us;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL R12 watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R12: reset state
      step(3);
      chk("R12", "reset pfc_en", int'(pfc_en), 0);
      chk("R12", "reset pwm_en", int'(pwm_en), 0);
      chk("R12", "reset ss_discharge", int'(ss_discharge), 1);
      chk("R12", "reset status", int'(status), 1);
      rst_n = 1'b1;

      // R1: lockout until turn-on seen
      req = "R1";
      sup_hold_ok = 1; rms_restart = 1; rms_brown_ok = 1; rms_sag_ok = 1;
      fb_ready = 1; fb_hold = 1; fb_loop_ok = 1; vamp_ok = 1; ss_ready = 1;
      step(5);
      chk("R1", "before turn-on pfc_en", int'(pfc_en), 0);
      chk("R1", "before turn-on status", int'(status), 1);
      sup_start_ok = 1;
      step(1);
      chk("R12", "one-edge latency pfc_en", int'(pfc_en), 1);
      chk("R10", "charging ss_discharge", int'(ss_discharge), 0);
      chk("R10", "charging pwm_en", int'(pwm_en), 0);
      step(1);
      chk("R1", "running pwm_en", int'(pwm_en), 1);
      sup_start_ok = 0;
      step(3);
      chk("R1", "hysteresis keeps pfc_en", int'(pfc_en), 1);
      sup_hold_ok = 0;
      step(1);
      chk("R1", "lockout pfc_en", int'(pfc_en), 0);
      chk("R1", "lockout ss_discharge", int'(ss_discharge), 1);
      sup_hold_ok = 1;
      step(2);
      chk("R1", "no restart without turn-on", int'(pfc_en), 0);
      sup_start_ok = 1;
      step(3);
      chk("R1", "restart pwm_en", int'(pwm_en), 1);

      // R2: supply over-voltage with hysteresis
      req = "R2";
      sup_over = 1; sup_over_hold = 1;
      step(1);
      chk("R2", "over-voltage pfc_en", int'(pfc_en), 0);
      chk("R11", "over-voltage status", int'(status), 2);
      sup_over = 0;
      step(3);
      chk("R2", "hysteresis holds off", int'(pwm_en), 0);
      sup_over_hold = 0;
      step(3);
      chk("R2", "recovered pwm_en", int'(pwm_en), 1);

      // R3: brownout debounce
      req = "R3";
      rms_restart = 0;
      step(2);
      rms_brown_ok = 0;
      step(10);
      chk("R3", "short dip pfc_en", int'(pfc_en), 1);
      rms_brown_ok = 1;
      step(2);
      rms_brown_ok = 0;
      step(50);
      chk("R3", "brownout pfc_en", int'(pfc_en), 0);
      chk("R3", "brownout pwm_en", int'(pwm_en), 1);
      chk("R11", "brownout status", int'(status), 4);

      // R4: restart only above restart level
      req = "R4";
      rms_brown_ok = 1;
      step(4);
      chk("R4", "mid-level line pfc_en", int'(pfc_en), 0);
      rms_restart = 1;
      step(1);
      chk("R4", "restart pfc_en", int'(pfc_en), 1);
      chk("R11", "normal status", int'(status), 0);

      // R5: sag timer
      req = "R5";
      rms_restart = 0; rms_brown_ok = 0; rms_sag_ok = 0;
      step(6);
      chk("R5", "early sag pfc_en", int'(pfc_en), 1);
      step(30);
      chk("R5", "sag trip pfc_en", int'(pfc_en), 0);
      chk("R5", "sag trip pwm_en", int'(pwm_en), 0);
      chk("R11", "sag status", int'(status), 3);
      rms_sag_ok = 1; rms_brown_ok = 1;
      req = "R4";
      step(3);
      chk("R4", "sag latched at mid level", int'(pfc_en), 0);
      rms_restart = 1;
      step(3);
      chk("R4", "sag release pwm_en", int'(pwm_en), 1);

      // R6: immediate sag trip
      req = "R6";
      rms_restart = 0; rms_sag_ok = 0;
      step(2);
      chk("R6", "sag level alone pfc_en", int'(pfc_en), 1);
      fb_hold = 0; fb_ready = 0;
      step(1);
      chk("R6", "immediate trip pfc_en", int'(pfc_en), 0);
      chk("R6", "immediate trip status", int'(status), 3);
      fb_hold = 1; fb_ready = 1; rms_sag_ok = 1; rms_restart = 1;
      step(3);
      chk("R6", "recovered pwm_en", int'(pwm_en), 1);

      // R7: converter ready gating
      req = "R7";
      fb_ready = 0;
      step(3);
      chk("R7", "ready latched pwm_en", int'(pwm_en), 1);
      fb_hold = 0;
      step(1);
      chk("R7", "drop pwm_en", int'(pwm_en), 0);
      chk("R7", "drop keeps pfc_en", int'(pfc_en), 1);
      chk("R11", "waiting status", int'(status), 7);
      fb_hold = 1;
      step(4);
      chk("R7", "needs ready again", int'(pwm_en), 0);
      fb_ready = 1;
      step(3);
      chk("R7", "ready pwm_en", int'(pwm_en), 1);

      // R8: boost over-voltage
      req = "R8";
      fb_over = 1; fb_over_hold = 1;
      step(1);
      chk("R8", "over pfc_en", int'(pfc_en), 0);
      chk("R8", "over keeps pwm_en", int'(pwm_en), 1);
      chk("R11", "over status", int'(status), 5);
      fb_over = 0;
      step(3);
      chk("R8", "hysteresis pfc_en", int'(pfc_en), 0);
      fb_over_hold = 0;
      step(1);
      chk("R8", "release pfc_en", int'(pfc_en), 1);

      // R9: open loop and low amplifier, not latched
      req = "R9";
      fb_loop_ok = 0;
      step(1);
      chk("R9", "open loop pfc_en", int'(pfc_en), 0);
      chk("R11", "open loop status", int'(status), 6);
      fb_loop_ok = 1;
      step(1);
      chk("R9", "loop back pfc_en", int'(pfc_en), 1);
      vamp_ok = 0;
      step(1);
      chk("R9", "low amp pfc_en", int'(pfc_en), 0);
      vamp_ok = 1;
      step(1);
      chk("R9", "amp back pfc_en", int'(pfc_en), 1);

      // R10: soft-start sequencing and same-edge collision
      req = "R10";
      ss_ready = 0; sup_hold_ok = 0; sup_start_ok = 0;
      step(1);
      chk("R10", "fault ss_discharge", int'(ss_discharge), 1);
      sup_hold_ok = 1; sup_start_ok = 1;
      step(1);
      chk("R10", "charging ss_discharge", int'(ss_discharge), 0);
      step(5);
      chk("R10", "no ss pwm_en", int'(pwm_en), 0);
      ss_ready = 1;
      step(1);
      chk("R10", "ss ready pwm_en", int'(pwm_en), 1);
      ss_ready = 0; sup_hold_ok = 0; sup_start_ok = 0;
      step(1);
      sup_hold_ok = 1; sup_start_ok = 1;
      step(2);
      ss_ready = 1; fb_hold = 0; fb_ready = 0;
      step(1);
      chk("R10", "collision pwm_en", int'(pwm_en), 0);
      chk("R10", "collision ss_discharge", int'(ss_discharge), 1);
      fb_hold = 1; fb_ready = 1;
      step(3);
      chk("R10", "after collision pwm_en", int'(pwm_en), 1);

      // R11: priority between lockout and sag
      req = "R11";
      sup_hold_ok = 0; sup_start_ok = 0; rms_sag_ok = 0; rms_restart = 0; fb_hold = 0;
      step(1);
      chk("R11", "lockout beats sag status", int'(status), 1);
      sup_hold_ok = 1; sup_start_ok = 1; rms_sag_ok = 1; rms_restart = 1;
      fb_hold = 1; fb_ready = 1;
      step(4);
      chk("R11", "final status", int'(status), 0);
      chk("R11", "final pwm_en", int'(pwm_en), 1);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

endmodule